// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block drives an 8-bit asynchronous NAND flash bus on behalf of a host that only wants to read. The host hands over one of four operations (device reset, identification read, full page read, spare-area read) together with a linear byte offset. The block then issues the command and address bytes with their latch strobes and waits for the device to finish its internal array fetch. Finally it clocks the data out with the read strobe and streams the bytes on a valid/ready channel.

The column and row address bytes are cut from the single linear offset. A spare-only read forces the column to point past the 2048-byte data area. A third row byte is added only when the configured device is larger than 128 MiB. A reset is followed by status polling until the device reports ready. An identification read compares the maker and device bytes against a fixed list of accepted parts. A busy timer ends any operation whose wait runs too long.

Top module: `nand_page_reader`

## Requirements
- R1: After reset the bus is idle: nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle and nand_ale are 0, done and rd_valid are 0, and op_ready is 1.
- R2: Every command or address byte is written with nand_cle (command) or nand_ale (address) high and the byte on nand_dq_o. The strobe is held for at least SETUP_CYC clocks before nand_we_n goes low for exactly one clock. nand_cle and nand_ale are never high together.
- R3: A page read (op_code 2) writes command 0x00, the address bytes, then command 0x30. It waits until nand_rb_n is 1, then delivers PAGE_BYTES+SPARE_BYTES bytes (2112 by default) in device order.
- R4: The address bytes are sent in this order: offset[7:0]; then offset[10:8] in bits 2:0 with the upper bits 0; then offset[18:11]; then offset[26:19]; then offset[34:27]. The last of these is sent only when DEV_MBYTES exceeds 128.
- R5: A spare read (op_code 3) follows R3 and R4, but sets bit 3 of the second address byte and delivers only SPARE_BYTES bytes (64).
- R6: A reset (op_code 0) writes command 0xFF and then 0x70. It reads status bytes until one has bit 6 set, and leaves the last status byte on status_byte.
- R7: An identification read (op_code 1) writes command 0x90 and one address byte 0x00, then reads a maker byte and a device byte. id_ok is 1 only for maker 0x2C with device 0xA1, 0xBA or 0xBC, or maker 0xEC with device 0xA1.
- R8: Each read strobe holds nand_re_n low for exactly ACCESS_CYC clocks. The byte is taken at the clock where nand_re_n returns high, and nand_re_n is never low while nand_we_n is low.
- R9: While rd_valid is 1 and rd_ready is 0, rd_valid and rd_data hold, and nand_re_n stays 1.
- R10: If nand_rb_n stays 0 for BUSY_LIMIT clocks, or a reset sees BUSY_LIMIT not-ready status bytes, the operation ends with done and timeout_err set and no data delivered.
- R11: An operation is accepted only when op_ready is 1. op_valid is ignored while an operation runs. nand_ce_n is 0 for the whole operation, and done pulses for one clock when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 reset, 1 identification, 2 page read, 3 spare read |
| op_offset | input | 35 | Linear byte offset |
| op_ready | output | 1 | Idle, request accepted |
| done | output | 1 | One-clock end-of-operation pulse |
| id_ok | output | 1 | Identification matched the accepted list |
| timeout_err | output | 1 | Busy wait exceeded its limit |
| status_byte | output | 8 | Last status byte read after reset |
| rd_valid | output | 1 | Stream byte valid |
| rd_data | output | 8 | Stream byte |
| rd_ready | input | 1 | Stream consumer ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus byte driven out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus byte from device |
| nand_rb_n | input | 1 | Device ready (1) or busy (0) |

## Verification
The assertions assume that the device pulls nand_rb_n low before the sequencer begins waiting on it, meaning within the hold time after the 0x30 write. They also assume that nand_dq_i is stable during the whole time nand_re_n is low. The bench model meets both conditions: it drops ready/busy on the same clock edge that latches the 0x30 command, and it drives the bus byte combinationally from its column pointer, which advances only after the read strobe has risen. rd_ready may change on any cycle, and the bench changes it only on falling clock edges so that holding cases are actually exercised.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam int OFF_W = 35;

  typedef enum logic [1:0] {
    OP_RESET      = 2'd0,
    OP_READ_ID    = 2'd1,
    OP_READ_PAGE  = 2'd2,
    OP_READ_SPARE = 2'd3
  } nand_op_e;

  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_ID     = 8'h90;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_FETCH  = 8'h30;

  // address byte number sel of a linear offset; spare forces column bit 11
  function automatic logic [7:0] addr_byte(input logic [OFF_W-1:0] off,
                                           input logic [2:0] sel,
                                           input logic spare);
    case (sel)
      3'd0:    return off[7:0];
      3'd1:    return {4'b0000, spare, off[10:8]};
      3'd2:    return off[18:11];
      3'd3:    return off[26:19];
      default: return off[34:27];
    endcase
  endfunction

  function automatic logic id_match(input logic [7:0] mfr, input logic [7:0] dev);
    return (mfr == 8'h2C && (dev == 8'hA1 || dev == 8'hBA || dev == 8'hBC)) ||
           (mfr == 8'hEC && dev == 8'hA1);
  endfunction
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle #(
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic       is_cmd,
  input  logic [7:0] wr_byte,
  input  logic [7:0] dq_i,
  output logic       done,
  output logic [7:0] rd_byte,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_o,
  output logic       dq_oe
);
  localparam int MAXC  = (SETUP_CYC > HOLD_CYC) ?
                         ((SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC) :
                         ((HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_RDLOW} bstate_e;
  bstate_e          state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       byte_q;
  logic             cmd_q;
  logic             wr_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= B_IDLE;
      cnt     <= '0;
      byte_q  <= '0;
      cmd_q   <= 1'b0;
      done    <= 1'b0;
      rd_byte <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        B_IDLE: if (start) begin
          cnt    <= '0;
          byte_q <= wr_byte;
          cmd_q  <= is_cmd;
          state  <= is_read ? B_RDLOW : B_SETUP;
        end
        B_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          cnt   <= '0;
          state <= B_PULSE;
        end else cnt <= cnt + 1'b1;
        B_PULSE: state <= B_HOLD;
        B_HOLD: if (cnt == CNT_W'(HOLD_CYC - 1)) begin
          done  <= 1'b1;
          state <= B_IDLE;
        end else cnt <= cnt + 1'b1;
        B_RDLOW: if (cnt == CNT_W'(ACCESS_CYC - 1)) begin
          rd_byte <= dq_i;
          done    <= 1'b1;
          state   <= B_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= B_IDLE;
      endcase
    end
  end

  assign wr_phase = (state == B_SETUP) || (state == B_PULSE) || (state == B_HOLD);
  assign cle   = wr_phase && cmd_q;
  assign ale   = wr_phase && !cmd_q;
  assign we_n  = (state != B_PULSE);
  assign re_n  = (state != B_RDLOW);
  assign dq_o  = byte_q;
  assign dq_oe = wr_phase;

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  p_we_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> we_n);
  p_we_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (cle || ale) && dq_oe);
  p_re_we_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == W'(LIMIT));

  p_expired_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !clear |=> expired);
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int DEV_MBYTES  = 256,
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_CYC    = 1,
  parameter int ACCESS_CYC  = 2,
  parameter int BUSY_LIMIT  = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic [OFF_W-1:0] op_offset,
  output logic             op_ready,
  output logic             done,
  output logic             id_ok,
  output logic             timeout_err,
  output logic [7:0]       status_byte,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_n
);
  localparam int XFER_TOTAL = PAGE_BYTES + SPARE_BYTES;
  localparam int XFER_W     = $clog2(XFER_TOTAL + 1);
  localparam int ADDR_CYC   = (DEV_MBYTES > 128) ? 5 : 4;

  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_RB, S_READ, S_STREAM, S_FIN} seq_e;
  seq_e              state;
  nand_op_e          op_q;
  logic [OFF_W-1:0]  off_q;
  logic              issued;
  logic [XFER_W-1:0] idx;
  logic [7:0]        mfr_q;

  logic              accept, issuing, bus_start, bus_done, bus_is_read, bus_is_cmd;
  logic [7:0]        bus_byte, bus_rd_byte;
  logic              tmr_tick, tmr_expired, poll_not_ready;
  logic [XFER_W-1:0] n_addr_last, xfer_last;

  assign op_ready    = (state == S_IDLE);
  assign accept      = op_valid && op_ready;
  assign nand_ce_n   = (state == S_IDLE);
  assign issuing     = (state == S_CMD1) || (state == S_ADDR) || (state == S_CMD2) || (state == S_READ);
  assign bus_start   = issuing && !issued;
  assign bus_is_read = (state == S_READ);
  assign bus_is_cmd  = (state == S_CMD1) || (state == S_CMD2);
  assign n_addr_last = (op_q == OP_READ_ID) ? '0 : XFER_W'(ADDR_CYC - 1);
  assign xfer_last   = (op_q == OP_READ_SPARE) ? XFER_W'(SPARE_BYTES - 1) : XFER_W'(XFER_TOTAL - 1);
  assign poll_not_ready = (state == S_READ) && bus_done && (op_q == OP_RESET) && !bus_rd_byte[6];
  assign tmr_tick    = ((state == S_RB) && !nand_rb_n) || poll_not_ready;

  always_comb begin
    bus_byte = 8'h00;
    case (state)
      S_CMD1: case (op_q)
        OP_RESET:   bus_byte = CMD_RESET;
        OP_READ_ID: bus_byte = CMD_ID;
        default:    bus_byte = CMD_READ;
      endcase
      S_CMD2: bus_byte = (op_q == OP_RESET) ? CMD_STATUS : CMD_FETCH;
      S_ADDR: bus_byte = (op_q == OP_READ_ID) ? 8'h00 :
                         addr_byte(off_q, idx[2:0], op_q == OP_READ_SPARE);
      default: bus_byte = 8'h00;
    endcase
  end

  nand_bus_cycle #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_read(bus_is_read), .is_cmd(bus_is_cmd),
    .wr_byte(bus_byte), .dq_i(nand_dq_i), .done(bus_done), .rd_byte(bus_rd_byte),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
  );

  nand_wait_timer #(.LIMIT(BUSY_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .tick(tmr_tick), .expired(tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op_q        <= OP_RESET;
      off_q       <= '0;
      issued      <= 1'b0;
      idx         <= '0;
      mfr_q       <= '0;
      done        <= 1'b0;
      id_ok       <= 1'b0;
      timeout_err <= 1'b0;
      status_byte <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      done <= 1'b0;
      if (bus_start) issued <= 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          op_q        <= nand_op_e'(op_code);
          off_q       <= op_offset;
          id_ok       <= 1'b0;
          timeout_err <= 1'b0;
          status_byte <= '0;
          idx         <= '0;
          state       <= S_CMD1;
        end
        S_CMD1: if (bus_done) begin
          issued <= 1'b0;
          state  <= (op_q == OP_RESET) ? S_CMD2 : S_ADDR;
        end
        S_ADDR: if (bus_done) begin
          issued <= 1'b0;
          if (idx == n_addr_last) begin
            idx   <= '0;
            state <= (op_q == OP_READ_ID) ? S_READ : S_CMD2;
          end else idx <= idx + 1'b1;
        end
        S_CMD2: if (bus_done) begin
          issued <= 1'b0;
          state  <= (op_q == OP_RESET) ? S_READ : S_RB;
        end
        S_RB: if (tmr_expired) begin
          timeout_err <= 1'b1;
          state       <= S_FIN;
        end else if (nand_rb_n) state <= S_READ;
        S_READ: if (bus_done) begin
          issued <= 1'b0;
          case (op_q)
            OP_RESET: begin
              status_byte <= bus_rd_byte;
              if (bus_rd_byte[6]) state <= S_FIN;
              else if (tmr_expired) begin
                timeout_err <= 1'b1;
                state       <= S_FIN;
              end
            end
            OP_READ_ID: if (idx == '0) begin
              mfr_q <= bus_rd_byte;
              idx   <= idx + 1'b1;
            end else begin
              id_ok <= id_match(mfr_q, bus_rd_byte);
              state <= S_FIN;
            end
            default: begin
              rd_valid <= 1'b1;
              rd_data  <= bus_rd_byte;
              state    <= S_STREAM;
            end
          endcase
        end
        S_STREAM: if (rd_ready) begin
          rd_valid <= 1'b0;
          if (idx == xfer_last) state <= S_FIN;
          else begin
            idx   <= idx + 1'b1;
            state <= S_READ;
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_stream_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  p_no_strobe_while_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> nand_re_n);
  p_timeout_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RB) && tmr_expired |=> (state == S_FIN) && timeout_err);
  p_timeout_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !rd_valid);
  p_ce_covers_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> op_ready && nand_ce_n);
endmodule

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;
  import nand_rd_pkg::*;

  localparam int SETUP = 2, HOLD = 1, ACCESS = 2, LIMIT = 40;
  localparam int PAGE = 2048, SPARE = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             op_valid = 1'b0;
  logic [1:0]       op_code = '0;
  logic [OFF_W-1:0] op_offset = '0;
  logic             op_ready, done, id_ok, timeout_err, rd_valid;
  logic [7:0]       status_byte, rd_data, nand_dq_o, nand_dq_i;
  logic             rd_ready = 1'b1;
  logic             nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb_n;

  nand_page_reader #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .ACCESS_CYC(ACCESS), .BUSY_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_offset(op_offset),
    .op_ready(op_ready), .done(done), .id_ok(id_ok), .timeout_err(timeout_err),
    .status_byte(status_byte), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] row, input logic [11:0] c);
    return 8'(c[7:0] + c[11:8] * 8'd29 + row[7:0] * 8'd53 + row[15:8] * 8'd7 + row[23:16] * 8'd3);
  endfunction

  // ---------------- device model ----------------
  logic        clr_req = 1'b0;
  int          cfg_polls = 3, busy_len = 10;
  logic [7:0]  m_mfr = 8'h00, m_dev = 8'h00;
  logic [7:0]  m_cmd [0:7];
  logic [7:0]  m_addr [0:4];
  int          m_ncmd = 0, m_nadr = 0, m_aidx = 0, m_busy = 0, m_polls = 0;
  logic [7:0]  m_last = 8'h00;
  logic [11:0] m_col = '0;
  logic        re_d = 1'b1, we_d = 1'b1;
  int          m_setup = 0, m_rerun = 0, we_viol = 0, re_viol = 0;

  always @(posedge clk) begin
    re_d <= nand_re_n;
    we_d <= nand_we_n;
    if (clr_req) begin
      m_ncmd  <= 0;
      m_nadr  <= 0;
      m_polls <= cfg_polls;
    end
    if (!nand_we_n) begin
      if (m_setup < SETUP || !we_d) we_viol <= we_viol + 1;
      m_setup <= 0;
      if (nand_cle) begin
        if (m_ncmd < 8) m_cmd[m_ncmd] <= nand_dq_o;
        m_ncmd <= m_ncmd + 1;
        m_last <= nand_dq_o;
        m_aidx <= 0;
        if (nand_dq_o == 8'h30) m_busy <= busy_len;
        if (nand_dq_o == 8'h90) m_col <= '0;
      end else if (nand_ale) begin
        if (m_nadr < 5) m_addr[m_nadr] <= nand_dq_o;
        m_nadr <= m_nadr + 1;
        m_aidx <= m_aidx + 1;
        if (m_aidx == 0) m_col[7:0] <= nand_dq_o;
        if (m_aidx == 1) m_col[11:8] <= nand_dq_o[3:0];
      end
    end else begin
      if (nand_cle || nand_ale) m_setup <= m_setup + 1;
      else m_setup <= 0;
      if (m_busy > 0) m_busy <= m_busy - 1;
    end
    if (!nand_re_n) m_rerun <= m_rerun + 1;
    else if (!re_d) begin
      if (m_rerun != ACCESS) re_viol <= re_viol + 1;
      m_rerun <= 0;
      m_col   <= m_col + 1'b1;
      if (m_last == 8'h70 && m_polls > 0) m_polls <= m_polls - 1;
    end
  end

  assign nand_rb_n = (m_busy == 0);
  always_comb begin
    case (m_last)
      8'h70:   nand_dq_i = (m_polls == 0) ? 8'h40 : 8'h00;
      8'h90:   nand_dq_i = (m_col == 12'd0) ? m_mfr : m_dev;
      default: nand_dq_i = pat({m_addr[4], m_addr[3], m_addr[2]}, m_col);
    endcase
  end

  // ---------------- stream consumer ----------------
  logic        bp_on = 1'b0;
  logic [23:0] exp_row = '0;
  logic [11:0] exp_col = '0;
  int          rx_n = 0, rx_bad = 0, hold_viol = 0;
  logic        hold_pend = 1'b0;
  logic [7:0]  hold_d = '0;

  always @(negedge clk) begin : ready_gen
    int bp_cnt;
    bp_cnt++;
    rd_ready <= bp_on ? (bp_cnt % 3 == 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (clr_req) begin
      rx_n   <= 0;
      rx_bad <= 0;
    end else if (rd_valid && rd_ready) begin
      if (rd_data != pat(exp_row, exp_col + 12'(rx_n))) rx_bad <= rx_bad + 1;
      rx_n <= rx_n + 1;
    end
    if (hold_pend && (!rd_valid || rd_data != hold_d)) hold_viol <= hold_viol + 1;
    hold_pend <= rd_valid && !rd_ready;
    hold_d    <= rd_data;
  end

  // ---------------- stimulus ----------------
  typedef struct packed {
    logic [1:0]       op;
    logic [OFF_W-1:0] off;
    logic [7:0]       mfr;
    logic [7:0]       dev;
    logic             exp_id;
    logic             bp;
  } vec_t;

  localparam vec_t VECS [0:10] = '{
    '{2'd0, 35'd0, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd1, 35'd0, 8'h2C, 8'hA1, 1'b1, 1'b0},
    '{2'd1, 35'd0, 8'h2C, 8'hBC, 1'b1, 1'b0},
    '{2'd1, 35'd0, 8'h2C, 8'hBA, 1'b1, 1'b0},
    '{2'd1, 35'd0, 8'hEC, 8'hBA, 1'b0, 1'b0},
    '{2'd1, 35'd0, 8'hEC, 8'hA1, 1'b1, 1'b0},
    '{2'd1, 35'd0, 8'h98, 8'hA1, 1'b0, 1'b0},
    '{2'd3, {8'h5A, 8'hC3, 8'h96, 11'h040}, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd2, {8'h01, 8'h02, 8'h03, 11'h000}, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd3, {8'h7F, 8'h00, 8'hFF, 11'h7C0}, 8'h00, 8'h00, 1'b0, 1'b1},
    '{2'd2, {8'h00, 8'h10, 8'h20, 11'h000}, 8'h00, 8'h00, 1'b0, 1'b1}
  };

  task automatic start_op(input logic [1:0] op, input logic [OFF_W-1:0] off);
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req   = 1'b0;
    op_valid  = 1'b1;
    op_code   = op;
    op_offset = off;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic finish_op;
    while (!done) @(negedge clk);
    while (!nand_rb_n) @(negedge clk);
  endtask

  task automatic check_read(input logic [1:0] op, input logic [OFF_W-1:0] off, input logic bp);
    logic spare;
    logic [7:0] e;
    string req;
    spare = (op == 2'd3);
    chk(m_ncmd == 2 && m_cmd[0] == 8'h00 && m_cmd[1] == 8'h30, "R3", "command pair",
        {m_cmd[0], m_cmd[1]}, 16'h0030);
    chk(m_nadr == 5, "R4", "address byte count", m_nadr, 5);
    for (int i = 0; i < 5; i++) begin
      if (i == 0)      e = off[7:0];
      else if (i == 1) e = 8'((off >> 8) & 35'h7) | (spare ? 8'h08 : 8'h00);
      else             e = 8'((off >> (11 + 8 * (i - 2))) & 35'hFF);
      req = (i == 1 && spare) ? "R5" : "R4";
      chk(m_addr[i] == e, req, $sformatf("address byte %0d", i), m_addr[i], e);
    end
    chk(rx_n == (spare ? SPARE : PAGE + SPARE), spare ? "R5" : "R3", "bytes streamed",
        rx_n, spare ? SPARE : PAGE + SPARE);
    chk(rx_bad == 0, "R3", "stream byte mismatches", rx_bad, 0);
    if (bp) chk(hold_viol == 0, "R9", "stream held under backpressure", hold_viol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: idle values during and right after reset
    chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, done, rd_valid, op_ready} == 8'b11100001,
        "R1", "reset state", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, done, rd_valid, op_ready},
        8'b11100001);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[k]) begin
      vec_t v;
      v       = VECS[k];
      m_mfr   = v.mfr;
      m_dev   = v.dev;
      bp_on   = v.bp;
      exp_row = v.off[34:11];
      exp_col = {(v.op == 2'd3), v.off[10:0]};
      start_op(v.op, v.off);
      finish_op();
      chk(timeout_err == 1'b0, "R10", "no timeout on normal op", timeout_err, 0);
      case (v.op)
        2'd0: begin
          chk(m_ncmd == 2 && m_cmd[0] == 8'hFF && m_cmd[1] == 8'h70, "R6", "reset commands",
              {m_cmd[0], m_cmd[1]}, 16'hFF70);
          chk(status_byte == 8'h40 && m_polls == 0, "R6", "status polled until ready",
              status_byte, 8'h40);
        end
        2'd1: begin
          chk(m_ncmd == 1 && m_cmd[0] == 8'h90, "R7", "id command", m_cmd[0], 8'h90);
          chk(m_nadr == 1 && m_addr[0] == 8'h00, "R7", "id address", m_nadr, 1);
          chk(id_ok == v.exp_id, "R7", $sformatf("id_ok for %02h/%02h", v.mfr, v.dev), id_ok, v.exp_id);
        end
        default: check_read(v.op, v.off, v.bp);
      endcase
    end
    bp_on = 1'b0;

    // R11: a request during a running page read is not taken
    exp_row = 24'h000001;
    exp_col = '0;
    start_op(2'd2, {8'h00, 8'h00, 8'h01, 11'h000});
    repeat (30) @(negedge clk);
    chk(op_ready == 1'b0 && nand_ce_n == 1'b0, "R11", "busy and selected mid-op",
        {op_ready, nand_ce_n}, 2'b00);
    op_valid = 1'b1;
    op_code  = 2'd0;
    @(negedge clk);
    op_valid = 1'b0;
    finish_op();
    chk(m_ncmd == 2 && m_cmd[1] == 8'h30, "R11", "ignored request left no command", m_ncmd, 2);
    chk(rx_n == PAGE + SPARE && rx_bad == 0, "R11", "running read completed", rx_n, PAGE + SPARE);

    // R10: device busy far past the limit
    busy_len = 1000;
    start_op(2'd3, 35'd0);
    while (!done) @(negedge clk);
    chk(timeout_err == 1'b1, "R10", "timeout flagged", timeout_err, 1);
    chk(rx_n == 0, "R10", "no data after timeout", rx_n, 0);
    finish_op();
    busy_len = 10;

    // R2 and R8: strobe shapes seen by the model over the whole run
    chk(we_viol == 0, "R2", "write strobe setup/width", we_viol, 0);
    chk(re_viol == 0, "R8", "read strobe width", re_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule